// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This unit holds the program counter of a small 8-bit controller whose program space is 4K words, so the counter is 12 bits wide. Each cycle an external decoder gives it a 3-bit operation code and the operand fields of the current instruction. The unit computes the next fetch address. It can increment, jump or call within the current 1K page, jump or call across a 2K span, return from the top of a circular hardware stack, add the accumulator to the low byte with carry, or overwrite only the low byte.

Long jumps and long calls take two cycles. A two-state controller handles them. In `ST_RUN` an instruction completes in its own cycle. A long jump or long call seen in `ST_RUN` captures its target and takes the `RUN_TO_LONG` transition into `ST_LONG`. In that state `stall` is high and the counter is held. In `ST_LONG` the target is loaded, the return address is pushed if the instruction was a call, and the controller always takes `LONG_TO_RUN` back to `ST_RUN`. An interrupt request accepted in `ST_RUN` saves the current address on the stack and redirects fetch to a fixed vector.

Top module: `pc_seq_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `fetch_addr` is 0 and `stall` is 0. The return stack is emptied and its entries are cleared to 0.
- R2: Op code 0 (sequential) gives `fetch_addr` + 1 on the next cycle, and 0xFFF wraps to 0x000.
- R3: Op code 1 (short jump) replaces `fetch_addr[9:0]` with `operand[9:0]` and keeps bits 11:10.
- R4: Op code 2 (short call) does the same as R3 and pushes the old `fetch_addr` + 1 onto the stack.
- R5: Op code 3 (long jump) holds `fetch_addr` and raises `stall` for exactly one cycle, taking the operand from the first cycle. It then replaces bits 10:0 with `operand[10:0]` and keeps bit 11. The op code, operand and `irq_take` presented during the stall cycle have no effect.
- R6: Op code 4 (long call) behaves like R5 and, when the target is loaded, pushes the long call's own address + 1.
- R7: Op code 5 (return) loads `fetch_addr` from the most recently pushed, not yet popped stack entry.
- R8: Op code 6 (add) sets `fetch_addr` to (`fetch_addr` + `acc`) mod 4096, so the carry out of the low byte reaches bit 8 and above.
- R9: Op code 7 (low write) sets `fetch_addr[7:0]` to `wr_data` and leaves bits 11:8 unchanged.
- R10: The stack holds 8 entries in a ring. A ninth push overwrites the oldest entry. A pop of an empty stack wraps the pointer and returns whatever is stored in that slot, with no error indication.
- R11: When `stall` is low, `irq_take` high overrides the op code. It pushes the current `fetch_addr` and loads the vector address 0x008.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Decoded operation code of the current instruction |
| operand | input | 11 | Jump/call target field; short forms use bits 9:0 |
| acc | input | 8 | Accumulator value for the add operation |
| wr_data | input | 8 | Data for a write to the low counter byte |
| irq_take | input | 1 | Accept an interrupt this cycle |
| fetch_addr | output | 12 | Current program counter / fetch address |
| stall | output | 1 | High during the second cycle of a long jump or call |

## Verification
The bench targets several corner cases.

- **Page boundaries.** A short jump that leaked into bit 10, or a low-byte write that cleared the upper nibble, would move fetch into the wrong page. An add without carry propagation would land 256 words short.
- **Stall cycle.** A controller that let the op code or interrupt from the stall cycle act would skip or redirect the long target. One that pushed the address + 1 of the wrong cycle would return one word off.
- **Stack ring.** Nine calls followed by nine returns, plus returns on an empty stack, expose a pointer that saturates instead of wrapping.
- **Counter wrap.** A full 4K sequential sweep exposes a counter that does not wrap at 0xFFF.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [2:0] {
        OP_SEQ   = 3'd0,
        OP_JMP   = 3'd1,
        OP_CALL  = 3'd2,
        OP_LJMP  = 3'd3,
        OP_LCALL = 3'd4,
        OP_RET   = 3'd5,
        OP_ADDPC = 3'd6,
        OP_WRPC  = 3'd7
    } pc_op_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_LONG = 1'b1
    } seq_state_e;

    typedef enum logic [2:0] {
        SRC_HOLD  = 3'd0,
        SRC_INC   = 3'd1,
        SRC_SHORT = 3'd2,
        SRC_LONG  = 3'd3,
        SRC_STACK = 3'd4,
        SRC_ADD   = 3'd5,
        SRC_LOW   = 3'd6,
        SRC_VEC   = 3'd7
    } pc_src_e;

endpackage

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] below;
    logic [W-1:0]     entry [DEPTH];

    assign below = ptr_q - 1'b1;
    assign top   = entry[below];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (push) begin
            ptr_q <= ptr_q + 1'b1;
        end else if (pop) begin
            ptr_q <= below;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry[g] <= '0;
            end else if (push && (ptr_q == PTR_W'(g))) begin
                entry[g] <= push_data;
            end
        end
    end

    // R10: ring pointer advances on push and wraps
    p_push_ptr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> ptr_q == $past(ptr_q) + 1'b1);

    // R7: a pop steps the pointer back by one
    p_pop_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> ptr_q == $past(ptr_q) - 1'b1);

    // R10: the controller never pushes and pops together
    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));

endmodule

// File: rtl/pcs_next_pc.sv
module pcs_next_pc
    import pcs_pkg::*;
#(
    parameter int          PC_W     = 12,
    parameter int          SHORT_W  = 10,
    parameter int          LONG_W   = 11,
    parameter int          BYTE_W   = 8,
    parameter logic [11:0] VEC_ADDR = 12'h008
) (
    input  pc_src_e             src,
    input  logic [PC_W-1:0]     pc,
    input  logic [SHORT_W-1:0]  short_tgt,
    input  logic [LONG_W-1:0]   long_tgt,
    input  logic [BYTE_W-1:0]   acc,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic [PC_W-1:0]     stack_top,
    output logic [PC_W-1:0]     pc_inc,
    output logic [PC_W-1:0]     nxt
);
    logic [PC_W-1:0] acc_ext;

    assign acc_ext = {{(PC_W-BYTE_W){1'b0}}, acc};
    assign pc_inc  = pc + 1'b1;

    always_comb begin
        unique case (src)
            SRC_HOLD:  nxt = pc;
            SRC_INC:   nxt = pc_inc;
            SRC_SHORT: nxt = {pc[PC_W-1:SHORT_W], short_tgt};
            SRC_LONG:  nxt = {pc[PC_W-1:LONG_W], long_tgt};
            SRC_STACK: nxt = stack_top;
            SRC_ADD:   nxt = pc + acc_ext;
            SRC_LOW:   nxt = {pc[PC_W-1:BYTE_W], wr_data};
            SRC_VEC:   nxt = VEC_ADDR[PC_W-1:0];
            default:   nxt = pc;
        endcase
    end

endmodule

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
    import pcs_pkg::*;
#(
    parameter int LONG_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pc_op_e            op,
    input  logic              irq_take,
    input  logic [LONG_W-1:0] operand,
    output pc_src_e           src,
    output logic              push,
    output logic              push_cur,
    output logic              pop,
    output logic              stall,
    output logic [LONG_W-1:0] long_tgt
);
    seq_state_e        state_q, state_d;
    logic [LONG_W-1:0] tgt_q;
    logic              lcall_q;
    logic              is_long;

    assign is_long  = (op == OP_LJMP) || (op == OP_LCALL);
    assign long_tgt = tgt_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            tgt_q   <= '0;
            lcall_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && !irq_take && is_long) begin
                tgt_q   <= operand;
                lcall_q <= (op == OP_LCALL);
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        src      = SRC_HOLD;
        push     = 1'b0;
        push_cur = 1'b0;
        pop      = 1'b0;
        stall    = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (irq_take) begin
                    src      = SRC_VEC;
                    push     = 1'b1;
                    push_cur = 1'b1;
                end else begin
                    unique case (op)
                        OP_SEQ:   src = SRC_INC;
                        OP_JMP:   src = SRC_SHORT;
                        OP_CALL: begin
                            src  = SRC_SHORT;
                            push = 1'b1;
                        end
                        OP_LJMP, OP_LCALL: begin
                            src     = SRC_HOLD;
                            state_d = ST_LONG;      // RUN_TO_LONG
                        end
                        OP_RET: begin
                            src = SRC_STACK;
                            pop = 1'b1;
                        end
                        OP_ADDPC: src = SRC_ADD;
                        OP_WRPC:  src = SRC_LOW;
                        default:  src = SRC_INC;
                    endcase
                end
            end
            ST_LONG: begin
                stall   = 1'b1;
                src     = SRC_LONG;
                push    = lcall_q;
                state_d = ST_RUN;                   // LONG_TO_RUN
            end
            default: state_d = ST_RUN;
        endcase
    end

    // R5: the long state lasts exactly one cycle
    p_long_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_LONG |=> state_q == ST_RUN);

    // R6: the long-call flag is captured only on the first cycle of a long op
    p_lcall_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !irq_take && op == OP_LCALL) |=> lcall_q);

endmodule

// File: rtl/pc_seq_unit.sv
module pc_seq_unit
    import pcs_pkg::*;
#(
    parameter int          PC_W      = 12,
    parameter int          SHORT_W   = 10,
    parameter int          LONG_W    = 11,
    parameter int          BYTE_W    = 8,
    parameter int          STK_DEPTH = 8,
    parameter logic [11:0] VEC_ADDR  = 12'h008
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op,
    input  logic [LONG_W-1:0] operand,
    input  logic [BYTE_W-1:0] acc,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              irq_take,
    output logic [PC_W-1:0]   fetch_addr,
    output logic              stall
);
    pc_op_e          op_e;
    pc_src_e         src;
    logic            push, push_cur, pop;
    logic [LONG_W-1:0] long_tgt;
    logic [PC_W-1:0] pc_q, pc_d, pc_inc, stack_top, push_data;

    assign op_e       = pc_op_e'(op);
    assign fetch_addr = pc_q;
    assign push_data  = push_cur ? pc_q : pc_inc;

    pcs_ctrl #(.LONG_W(LONG_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op_e),
        .irq_take (irq_take),
        .operand  (operand),
        .src      (src),
        .push     (push),
        .push_cur (push_cur),
        .pop      (pop),
        .stall    (stall),
        .long_tgt (long_tgt)
    );

    pcs_next_pc #(
        .PC_W(PC_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W),
        .BYTE_W(BYTE_W), .VEC_ADDR(VEC_ADDR)
    ) u_next (
        .src       (src),
        .pc        (pc_q),
        .short_tgt (operand[SHORT_W-1:0]),
        .long_tgt  (long_tgt),
        .acc       (acc),
        .wr_data   (wr_data),
        .stack_top (stack_top),
        .pc_inc    (pc_inc),
        .nxt       (pc_d)
    );

    pcs_ret_stack #(.DEPTH(STK_DEPTH), .W(PC_W)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .push_data (push_data),
        .top       (stack_top)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    // R2: sequential step
    p_seq_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !irq_take && op_e == OP_SEQ)
        |=> fetch_addr == PC_W'($past(fetch_addr) + 1'b1));

    // R3: short jump stays in its page
    p_short_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !irq_take && op_e == OP_JMP)
        |=> fetch_addr[PC_W-1:SHORT_W] == $past(fetch_addr[PC_W-1:SHORT_W])
            && fetch_addr[SHORT_W-1:0] == $past(operand[SHORT_W-1:0]));

    // R5: a long op stalls and holds the address
    p_long_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !irq_take && (op_e == OP_LJMP || op_e == OP_LCALL))
        |=> stall && fetch_addr == $past(fetch_addr));

    // R5: stall never lasts two cycles
    p_stall_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    // R9: low write keeps the upper bits
    p_wrlow_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !irq_take && op_e == OP_WRPC)
        |=> fetch_addr[PC_W-1:BYTE_W] == $past(fetch_addr[PC_W-1:BYTE_W])
            && fetch_addr[BYTE_W-1:0] == $past(wr_data));

    // R11: accepted interrupt goes to the vector
    p_irq_vec_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && irq_take) |=> fetch_addr == VEC_ADDR[PC_W-1:0]);

endmodule

// File: tb/tb_pc_seq_unit.sv
`timescale 1ns/1ps
module tb_pc_seq_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  op;
    logic [10:0] operand;
    logic [7:0]  acc, wr_data;
    logic        irq_take;
    logic [11:0] fetch_addr;
    logic        stall;

    int n_checks = 0;
    int n_fails  = 0;

    // reference model state
    logic [11:0] m_pc;
    logic [11:0] m_stk [8];
    int          m_ptr;
    bit          m_long, m_lcall;
    logic [10:0] m_lt;
    logic [15:0] lf = 16'hACE1;

    always #5 clk = ~clk;

    pc_seq_unit dut (
        .clk(clk), .rst_n(rst_n), .op(op), .operand(operand), .acc(acc),
        .wr_data(wr_data), .irq_take(irq_take), .fetch_addr(fetch_addr), .stall(stall)
    );

    task automatic check(input string tag, input logic [11:0] exp_pc, input logic exp_st);
        n_checks++;
        if (fetch_addr !== exp_pc || stall !== exp_st) begin
            n_fails++;
            $display("FAIL %s: addr=%03h stall=%0b expected addr=%03h stall=%0b",
                     tag, fetch_addr, stall, exp_pc, exp_st);
        end
    endtask

    task automatic m_push(input logic [11:0] v);
        m_stk[m_ptr] = v;
        m_ptr = (m_ptr + 1) % 8;
    endtask

    task automatic m_reset();
        m_pc = '0; m_ptr = 0; m_long = 0; m_lcall = 0; m_lt = '0;
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op = '0; operand = '0; acc = '0; wr_data = '0; irq_take = 1'b0;
        repeat (3) @(negedge clk);
        m_reset();
        check("R1", 12'h000, 1'b0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        m_pc = 12'h001;   // first cycle executes SEQ
        check("R1", m_pc, 1'b0);
    endtask

    task automatic step(input logic [2:0] o, input logic [10:0] opd, input logic [7:0] a,
                        input logic [7:0] w, input logic irq, input string tag);
        @(negedge clk);
        op = o; operand = opd; acc = a; wr_data = w; irq_take = irq;
        if (m_long) begin
            if (m_lcall) m_push(m_pc + 12'd1);
            m_pc = {m_pc[11], m_lt};
            m_long = 0;
        end else if (irq) begin
            m_push(m_pc);
            m_pc = 12'h008;
        end else begin
            case (o)
                3'd0: m_pc = m_pc + 12'd1;
                3'd1: m_pc = {m_pc[11:10], opd[9:0]};
                3'd2: begin m_push(m_pc + 12'd1); m_pc = {m_pc[11:10], opd[9:0]}; end
                3'd3, 3'd4: begin m_long = 1; m_lcall = (o == 3'd4); m_lt = opd; end
                3'd5: begin m_ptr = (m_ptr + 7) % 8; m_pc = m_stk[m_ptr]; end
                3'd6: m_pc = m_pc + {4'h0, a};
                default: m_pc = {m_pc[11:8], w};
            endcase
        end
        @(posedge clk); #1;
        check(tag, m_pc, m_long);
    endtask

    function automatic logic [15:0] lfsr(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        do_reset();

        // R2: full sweep over 4K words, wrapping at 0xFFF
        for (int i = 0; i < 4100; i++) step(3'd0, '0, '0, '0, 1'b0, "R2");

        // R3: short jumps in every page
        for (int pg = 0; pg < 4; pg++) begin
            step(3'd7, '0, '0, 8'h00, 1'b0, "R9");
            for (int k = 0; k < 64; k++)
                step(3'd1, 11'((k * 97 + pg * 13) % 2048), '0, '0, 1'b0, "R3");
            for (int s = 0; s < 4; s++) step(3'd6, '0, 8'hFF, '0, 1'b0, "R8");
        end

        // R8: every accumulator value from a page-crossing base
        for (int a = 0; a < 256; a++) begin
            step(3'd7, '0, '0, 8'(a ^ 8'h5A), 1'b0, "R9");
            step(3'd6, '0, 8'(a), '0, 1'b0, "R8");
        end

        // R9: low write from a high page keeps bits 11:8
        step(3'd6, '0, 8'hFF, '0, 1'b0, "R8");
        for (int w = 0; w < 256; w += 17) step(3'd7, '0, '0, 8'(w), 1'b0, "R9");

        // R5/R6: long ops with junk during the stall cycle
        step(3'd3, 11'h7A5, '0, '0, 1'b0, "R5");
        step(3'd2, 11'h123, 8'h44, 8'h99, 1'b1, "R5");
        step(3'd4, 11'h015, '0, '0, 1'b0, "R6");
        step(3'd5, 11'h3FF, '0, '0, 1'b1, "R6");
        step(3'd5, '0, '0, '0, 1'b0, "R7");

        // R10: nine calls overwrite oldest, then ten returns wrap
        for (int c = 0; c < 9; c++) step(3'd2, 11'(c * 40 + 3), '0, '0, 1'b0, "R4");
        for (int r = 0; r < 10; r++) step(3'd5, '0, '0, '0, 1'b0, "R10");

        // R11: interrupt overrides op, then return
        step(3'd1, 11'h2F0, '0, '0, 1'b1, "R11");
        step(3'd5, '0, '0, '0, 1'b0, "R11");

        // mixed stream of all operations
        for (int i = 0; i < 3000; i++) begin
            lf = lfsr(lf);
            step(lf[2:0], {lf[10:3], lf[15:13]}, lf[15:8], lf[7:0], lf[11] & lf[12] & lf[4], "R7");
        end

        // R1: reset after activity
        do_reset();
        step(3'd5, '0, '0, '0, 1'b0, "R10");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule